// File: doc/BRIEF.md
# Paired-Width Integer Register File

This block is the integer register file of a 32-bit core that also keeps 64-bit floating-point values in its integer registers. It holds 32 registers of 32 bits. There are two read ports and one write port. Each port has its own width select. In single mode a port works on one register. In paired mode it works on a 64-bit value spread over an even/odd register pair. The even register carries bits 31:0 and the register above it carries bits 63:32, whatever the memory byte order.

Register 0 behaves specially in both modes. A single read of register 0 returns zero, and a single write to it is dropped. A paired read based at register 0 returns a full 64-bit zero and does not touch register 1. A paired write based at register 0 is discarded as a whole, so register 1 keeps its value. A paired access with an odd base register is reserved. The port raises its illegal flag, a paired write with an odd base is suppressed, and a paired read with an odd base returns zero.

Reads are combinational. A write takes effect at the rising clock edge and can be read from the next cycle on. There is no write-to-read bypass. A 64-bit register copy is one paired read followed by one paired write of the same value. All pins are plain level signals, with no handshake, because the file always accepts a write and always answers a read in the same cycle.

Top module: `pairrf_regfile`

## Requirements
- R1: An active-low synchronous reset clears every register, so all reads return zero after reset.
- R2: A single-mode read (pair select 0) returns the named register in bits 31:0 and zero in bits 63:32. Register 0 always reads as zero.
- R3: A single-mode write stores write data bits 31:0 into the named register only. A write to register 0 has no effect.
- R4: A paired read (pair select 1) with even base n returns register n in bits 31:0 and register n+1 in bits 63:32.
- R5: A paired write with even nonzero base n stores data bits 31:0 into register n and bits 63:32 into register n+1, both at the same clock edge.
- R6: A paired write with base 0 is discarded entirely, and register 1 keeps its value.
- R7: A paired read with base 0 returns 64 bits of zero, even when register 1 holds nonzero data.
- R8: A paired read with an odd base raises that port's illegal flag in the same cycle and returns zero. Single reads never raise the flag.
- R9: A paired write with an odd base raises the write illegal flag (while write enable is high) and changes no register.
- R10: Written data becomes visible on the read ports only in the cycle after the write edge. A read in the same cycle as the write returns the old value.
- R11: The two read ports work independently, each with its own index and width select.
- R12: Feeding a paired read result into a paired write to another even base copies the whole 64-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_idx | input | 5 | Read port A register index |
| ra_pair | input | 1 | Read port A width select (1 = 64-bit pair) |
| ra_data | output | 64 | Read port A data |
| ra_illegal | output | 1 | Read port A odd pair base flag |
| rb_idx | input | 5 | Read port B register index |
| rb_pair | input | 1 | Read port B width select (1 = 64-bit pair) |
| rb_data | output | 64 | Read port B data |
| rb_illegal | output | 1 | Read port B odd pair base flag |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_pair | input | 1 | Write width select (1 = 64-bit pair) |
| wr_data | input | 64 | Write data; only bits 31:0 are used in single mode |
| wr_illegal | output | 1 | Write odd pair base flag |

## Verification
The stimulus mixes single and paired writes that use distinct high and low words. This exposes swapped halves, a missing upper-half write, and an upper half left over from a single write. Base-zero paired accesses are tried after register 1 has been loaded with a nonzero value, which separates true whole-pair suppression from plain register-0 masking. Odd bases are driven on every port, and the neighbouring registers are read back afterwards to show that nothing moved. Reads are also issued in the same cycle as a write to the same register, which tells a bypass apart from the required next-cycle visibility.

// File: rtl/pairrf_pkg.sv
package pairrf_pkg;
  parameter int unsigned NREG = 32;
  parameter int unsigned XW   = 32;
  localparam int unsigned IW  = $clog2(NREG);
  localparam int unsigned DW  = 2 * XW;
  typedef logic [XW-1:0] word_t;
  typedef logic [DW-1:0] dword_t;
  typedef logic [IW-1:0] ridx_t;
endpackage

// File: rtl/pairrf_rdport.sv
module pairrf_rdport
  import pairrf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  word_t  regs [NREG],
  input  ridx_t  idx,
  input  logic   pair,
  output dword_t data,
  output logic   illegal
);
  ridx_t  hi_idx;
  logic   base_zero;

  assign hi_idx    = {idx[IW-1:1], 1'b1};
  assign base_zero = (idx == '0);
  assign illegal   = pair & idx[0];

  always_comb begin
    data = '0;
    if (!pair) begin
      if (!base_zero) data[XW-1:0] = regs[idx];
    end else if (!illegal && !base_zero) begin
      data = {regs[hi_idx], regs[idx]};
    end
  end

  // R7: a paired read based at register 0 is all zero
  a_r7_pair_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
    (pair && idx == '0) |-> data == '0);
  // R8: an odd paired base yields the flag and zero data
  a_r8_odd_read: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (data == '0 && pair));
  // R2: a single read never drives the upper half
  a_r2_single_upper: assert property (@(posedge clk) disable iff (!rst_n)
    !pair |-> data[DW-1:XW] == '0);
endmodule

// File: rtl/pairrf_wrdec.sv
module pairrf_wrdec
  import pairrf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  ridx_t           idx,
  input  logic            pair,
  output logic [NREG-1:0] wen,
  output logic            illegal
);
  ridx_t hi_idx;
  assign hi_idx  = {idx[IW-1:1], 1'b1};
  assign illegal = we & pair & idx[0];

  always_comb begin
    wen = '0;
    if (we && !(pair && idx[0]) && idx != '0) begin
      wen[idx] = 1'b1;
      if (pair) wen[hi_idx] = 1'b1;
    end
  end

  // R9: an odd paired base enables no register
  a_r9_odd_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> wen == '0);
  // R6: writes based at register 0 enable nothing
  a_r6_zero_base_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx == '0) |-> wen == '0);
  // R5: a valid paired write enables exactly two registers
  a_r5_pair_two_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (we && pair && !idx[0] && idx != '0) |-> $countones(wen) == 2);
  // R3: a single write enables at most one register
  a_r3_single_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !pair |-> $onehot0(wen));
endmodule

// File: rtl/pairrf_regfile.sv
module pairrf_regfile
  import pairrf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  ra_idx,
  input  logic        ra_pair,
  output logic [63:0] ra_data,
  output logic        ra_illegal,
  input  logic [4:0]  rb_idx,
  input  logic        rb_pair,
  output logic [63:0] rb_data,
  output logic        rb_illegal,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic        wr_pair,
  input  logic [63:0] wr_data,
  output logic        wr_illegal
);
  word_t           regs [NREG];
  logic [NREG-1:0] wen;

  pairrf_wrdec u_wrdec (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .idx(wr_idx), .pair(wr_pair),
    .wen(wen), .illegal(wr_illegal)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_live
      localparam bit ODD = (i % 2) == 1;
      always_ff @(posedge clk) begin
        if (!rst_n)
          regs[i] <= '0;
        else if (wen[i])
          regs[i] <= (wr_pair && ODD) ? wr_data[DW-1:XW] : wr_data[XW-1:0];
      end
    end
  end

  pairrf_rdport u_rda (
    .clk(clk), .rst_n(rst_n), .regs(regs), .idx(ra_idx), .pair(ra_pair),
    .data(ra_data), .illegal(ra_illegal)
  );
  pairrf_rdport u_rdb (
    .clk(clk), .rst_n(rst_n), .regs(regs), .idx(rb_idx), .pair(rb_pair),
    .data(rb_data), .illegal(rb_illegal)
  );

  // R6: a paired write based at register 0 leaves register 1 untouched
  a_r6_r1_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pair && wr_idx == '0) |=> $stable(regs[1]));
  // R9: an odd paired write leaves its own register untouched
  a_r9_odd_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pair && wr_idx == 5'd3) |=> $stable(regs[3]));
endmodule

// File: tb/tb_pairrf_regfile.sv
`timescale 1ns/1ps
module tb_pairrf_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic        ra_pair = 1'b0, rb_pair = 1'b0, wr_pair = 1'b0, wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] ra_data, rb_data;
  logic        ra_illegal, rb_illegal, wr_illegal;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] model [32];

  always #4 clk = ~clk;

  pairrf_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(ra_idx), .ra_pair(ra_pair), .ra_data(ra_data), .ra_illegal(ra_illegal),
    .rb_idx(rb_idx), .rb_pair(rb_pair), .rb_data(rb_data), .rb_illegal(rb_illegal),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_pair(wr_pair), .wr_data(wr_data),
    .wr_illegal(wr_illegal)
  );

  function automatic logic [63:0] exp_rd(input logic [4:0] i, input logic p);
    if (!p) return (i == 0) ? 64'd0 : {32'd0, model[i]};
    if (i[0] || i == 0) return 64'd0;
    return {model[i | 5'd1], model[i]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_a(input string req, input logic [4:0] i, input logic p);
    ra_idx = i; ra_pair = p; #1;
    check(req, ra_data, exp_rd(i, p));
    check(req, {63'd0, ra_illegal}, {63'd0, p & i[0]});
  endtask

  task automatic rd_b(input string req, input logic [4:0] i, input logic p);
    rb_idx = i; rb_pair = p; #1;
    check(req, rb_data, exp_rd(i, p));
    check(req, {63'd0, rb_illegal}, {63'd0, p & i[0]});
  endtask

  // drive a write at the falling edge, commit at the rising edge, update model
  task automatic wr(input string req, input logic [4:0] i, input logic p, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_pair = p; wr_data = d; #1;
    check(req, {63'd0, wr_illegal}, {63'd0, p & i[0]});
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (i != 0 && !(p && i[0])) begin
      model[i] = d[31:0];
      if (p) model[i | 5'd1] = d[63:32];
    end
  endtask

  task automatic t_reset;
    for (int k = 0; k < 32; k++) rd_a("R1", k[4:0], 1'b0);
    for (int k = 0; k < 32; k += 2) rd_b("R1", k[4:0], 1'b1);
  endtask

  task automatic t_single;
    wr("R3", 5'd5, 1'b0, 64'hDEAD_BEEF_1234_5678);
    rd_a("R2", 5'd5, 1'b0);
    rd_a("R3", 5'd4, 1'b0);
    rd_a("R3", 5'd6, 1'b0);
    wr("R3", 5'd0, 1'b0, 64'h0000_0000_FFFF_FFFF);
    rd_a("R2", 5'd0, 1'b0);
  endtask

  task automatic t_pair;
    wr("R5", 5'd10, 1'b1, 64'hAAAA_0001_5555_0002);
    rd_a("R4", 5'd10, 1'b1);
    rd_a("R5", 5'd10, 1'b0);
    rd_b("R5", 5'd11, 1'b0);
    wr("R5", 5'd30, 1'b1, 64'h0123_4567_89AB_CDEF);
    rd_a("R4", 5'd30, 1'b1);
    check("R4", ra_data, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_zero_pair;
    wr("R3", 5'd1, 1'b0, 64'h0000_0000_CAFE_F00D);
    rd_a("R6", 5'd1, 1'b0);
    rd_a("R7", 5'd0, 1'b1);
    check("R7", ra_data, 64'd0);
    wr("R6", 5'd0, 1'b1, 64'h1111_2222_3333_4444);
    rd_a("R6", 5'd1, 1'b0);
    check("R6", ra_data, 64'h0000_0000_CAFE_F00D);
  endtask

  task automatic t_odd;
    wr("R3", 5'd3, 1'b0, 64'h0000_0000_0BAD_0003);
    wr("R3", 5'd4, 1'b0, 64'h0000_0000_0BAD_0004);
    wr("R9", 5'd3, 1'b1, 64'h7777_7777_8888_8888);
    rd_a("R9", 5'd3, 1'b0);
    rd_b("R9", 5'd4, 1'b0);
    rd_a("R9", 5'd2, 1'b0);
    rd_a("R8", 5'd3, 1'b1);
    rd_b("R8", 5'd5, 1'b1);
    rd_a("R8", 5'd3, 1'b0);
  endtask

  task automatic t_nobypass;
    rd_a("R10", 5'd12, 1'b1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd12; wr_pair = 1'b1; wr_data = 64'hFACE_0012_FEED_0034;
    ra_idx = 5'd12; ra_pair = 1'b1; #1;
    check("R10", ra_data, exp_rd(5'd12, 1'b1));
    @(posedge clk); #1;
    wr_en = 1'b0;
    model[12] = 32'hFEED_0034; model[13] = 32'hFACE_0012;
    check("R10", ra_data, 64'hFACE_0012_FEED_0034);
  endtask

  task automatic t_ports_copy;
    ra_idx = 5'd10; ra_pair = 1'b1; rb_idx = 5'd5; rb_pair = 1'b0; #1;
    check("R11", ra_data, exp_rd(5'd10, 1'b1));
    check("R11", rb_data, exp_rd(5'd5, 1'b0));
    rd_a("R12", 5'd30, 1'b1);
    wr("R12", 5'd20, 1'b1, ra_data);
    rd_b("R12", 5'd20, 1'b1);
    check("R12", rb_data, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int k = 0; k < 32; k++) model[k] = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_single();
    t_pair();
    t_zero_pair();
    t_odd();
    t_nobypass();
    t_ports_copy();
    summary();
  end
endmodule